// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block decides whether a decoded system-level instruction may run in the hart's current privilege state. It takes the active privilege mode, a one-hot instruction class, the trap-control bits, the floating-point and vector context status, the stored rounding mode and the cache-block enable fields of three environment-configuration levels. From these it reports one of three results:

- an illegal-instruction exception;
- a virtual-instruction exception;
- for a cache-block invalidate that is allowed, a request to carry it out as a flush.

The decoder presents a request with `inValid`. The verdict appears one clock later with `outValid`, so the check sits in a single pipeline stage beside decode. Illegal outranks virtual. Flush conversion is reported only when neither exception fires.

Top module: `priv_legal_chk`

## Requirements
- R1: A request sampled with `inValid` high at a rising edge produces `outValid` high after that edge, with the three flags computed from that request. After an edge where `inValid` was low, `outValid`, `illegalOut`, `virtualOut` and `flushOut` are all 0. Reset clears all four.
- R2: Mode codes are M=0, HS=1, HU=2, VS=3, VU=4. Class bit 0 (address-translation fence) is illegal in HS with `tvm`=1 and always illegal in HU. It is virtual in VS with `vtvm`=1 and always virtual in VU. Class bit 2 (guest-physical hypervisor fence) has the same illegal condition and is virtual in VS or VU.
- R3: Class bit 1 (partial fence: write-invalidate / invalidate-ir) is illegal in HU and virtual in VU, and legal in every other mode.
- R4: Class bit 3 (guest-virtual hypervisor fence) is illegal only in HU and virtual in VS or VU. `tvm` has no effect on it.
- R5: Class bit 4 (hypervisor load/store) is illegal in HU when `hstatusHu`=0 and virtual in VS or VU.
- R6: Class bit 7 (wait-for-interrupt) is illegal in HU, or in any non-M mode when `tw`=1. It is virtual in VU when `tw`=0, and in VS when `tw`=0 and `vtw`=1.
- R7: Class bit 5 (floating point) is illegal when `fsState`=2'b00 (Off) or when `roundMode` is greater than 4. Class bit 6 (vector) is illegal when `vsState`=2'b00. These two classes apply in every mode, including M.
- R8: The environment vectors use bit 0 for machine, bit 1 for hypervisor and bit 2 for supervisor. Class bit 8 (cache-block zero) uses `envCbze`, and class bit 9 (cache-block clean/flush) uses `envCbcfe` in the same way. The class is illegal when the mode is not M and the machine bit is 0, or when the mode is HU and the supervisor bit is 0. It is virtual when the machine bit is 1 and either the mode is VS with the hypervisor bit 0, or the mode is VU with the hypervisor or supervisor bit 0.
- R9: Class bit 10 (cache-block invalidate) reads 2-bit fields from `envCbie`: machine [1:0], hypervisor [3:2], supervisor [5:4]. A field value of 00 means disabled, 01 means Flush, 11 means Invalidate, and 10 is treated as disabled. The illegal and virtual rules are those of R8, with "bit is 0" read as "field is disabled".
- R10: An allowed class-10 request sets `flushOut` when any field on the mode's path equals Flush. The paths are: HS checks machine; HU checks machine and supervisor; VS checks machine and hypervisor; VU checks all three. M never converts.
- R11: `illegalOut` and `virtualOut` are never both 1; when the illegal condition of any selected class holds, only `illegalOut` is set. `flushOut` is 1 only when neither exception is set.
- R12: In modes M, HS and HU `virtualOut` is never set. In M only classes 5 and 6 can set `illegalOut`. A request with no class bit set yields all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| privMode | input | 3 | Current privilege mode code |
| instClass | input | 11 | One-hot instruction class |
| tvm | input | 1 | Trap address-translation fences in HS |
| vtvm | input | 1 | Trap address-translation fences in VS |
| tw | input | 1 | Trap wait-for-interrupt outside M |
| vtw | input | 1 | Trap wait-for-interrupt in VS |
| hstatusHu | input | 1 | Allow hypervisor load/store from HU |
| fsState | input | 2 | Floating-point context status |
| vsState | input | 2 | Vector context status |
| roundMode | input | 3 | Stored floating-point rounding mode |
| envCbze | input | 3 | Cache-block zero enables per level |
| envCbcfe | input | 3 | Cache-block clean/flush enables per level |
| envCbie | input | 6 | Cache-block invalidate fields per level |
| outValid | output | 1 | Verdict valid |
| illegalOut | output | 1 | Raise illegal-instruction exception |
| virtualOut | output | 1 | Raise virtual-instruction exception |
| flushOut | output | 1 | Perform the invalidate as a flush |

## Verification
Each class is driven across the modes that separate its two trap levels. The cases toggle the one control bit (`tvm`, `vtvm`, `tw`, `vtw`, `hstatusHu`) that flips a request between legal, illegal and virtual, so a wrong mode term or a swapped control bit shows up as a wrong flag. The cache-block cases clear one environment level at a time, which tells a missing level in the illegal path apart from one in the virtual path. The flush cases place the Flush code on levels that are on and off each mode's path. Multi-hot requests and a Flush code hidden behind a virtual trap test the priority order.

// File: rtl/priv_legal_pkg.sv
package priv_legal_pkg;

  localparam int MODE_W    = 3;
  localparam int NUM_CLASS = 11;
  localparam int NUM_ENV   = 3;
  localparam int NUM_CBO   = 3;

  localparam logic [MODE_W-1:0] PM_M  = 3'd0;
  localparam logic [MODE_W-1:0] PM_HS = 3'd1;
  localparam logic [MODE_W-1:0] PM_HU = 3'd2;
  localparam logic [MODE_W-1:0] PM_VS = 3'd3;
  localparam logic [MODE_W-1:0] PM_VU = 3'd4;

  // class bit positions
  localparam int CL_SFVMA  = 0;
  localparam int CL_SFPART = 1;
  localparam int CL_HFGV   = 2;
  localparam int CL_HFVV   = 3;
  localparam int CL_HLSV   = 4;
  localparam int CL_FP     = 5;
  localparam int CL_VEC    = 6;
  localparam int CL_WFI    = 7;
  localparam int CL_CBZ    = 8;
  localparam int CL_CBCF   = 9;
  localparam int CL_CBI    = 10;

  // environment level positions
  localparam int LV_M = 0;
  localparam int LV_H = 1;
  localparam int LV_S = 2;

  localparam logic [1:0] CBIE_OFF   = 2'b00;
  localparam logic [1:0] CBIE_FLUSH = 2'b01;
  localparam logic [1:0] CBIE_RSVD  = 2'b10;
  localparam logic [1:0] CBIE_INV   = 2'b11;

  localparam logic [1:0] CTX_OFF = 2'b00;

  typedef struct packed {
    logic capture;
    logic clear;
  } dpStrobe_t;

endpackage

// File: rtl/priv_legal_ctl.sv
module priv_legal_ctl
  import priv_legal_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output dpStrobe_t strb,
  output logic      outValid
);

  always_comb begin
    strb.capture = inValid;
    strb.clear   = !inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/priv_legal_dp.sv
module priv_legal_dp
  import priv_legal_pkg::*;
#(
  parameter int CLASS_N  = NUM_CLASS,
  parameter int ENV_LVLS = NUM_ENV,
  parameter int RM_W     = 3,
  parameter int RM_MAX   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [MODE_W-1:0]     privMode,
  input  logic [CLASS_N-1:0]    instClass,
  input  logic                  tvm,
  input  logic                  vtvm,
  input  logic                  tw,
  input  logic                  vtw,
  input  logic                  hstatusHu,
  input  logic [1:0]            fsState,
  input  logic [1:0]            vsState,
  input  logic [RM_W-1:0]       roundMode,
  input  logic [ENV_LVLS-1:0]   envCbze,
  input  logic [ENV_LVLS-1:0]   envCbcfe,
  input  logic [2*ENV_LVLS-1:0] envCbie,
  output logic                  illegalQ,
  output logic                  virtualQ,
  output logic                  flushQ
);

  localparam logic [RM_W-1:0] RM_LIMIT = RM_W'(RM_MAX);

  logic isM, isHS, isHU, isVS, isVU, notM;
  logic [ENV_LVLS-1:0] cbieOn, cbieFlush, pathMask;
  logic [ENV_LVLS-1:0] cboEn [NUM_CBO];
  logic [NUM_CBO-1:0]  cboIll, cboVir;
  logic [CLASS_N-1:0]  illV, virV;
  logic anyIll, anyVir, flushPath, nextIll, nextVir, nextFlush;

  always_comb begin
    isM  = (privMode == PM_M);
    isHS = (privMode == PM_HS);
    isHU = (privMode == PM_HU);
    isVS = (privMode == PM_VS);
    isVU = (privMode == PM_VU);
    notM = isHS || isHU || isVS || isVU;
  end

  for (genvar l = 0; l < ENV_LVLS; l++) begin : g_lvl
    assign cbieOn[l]    = (envCbie[2*l +: 2] != CBIE_OFF) && (envCbie[2*l +: 2] != CBIE_RSVD);
    assign cbieFlush[l] = (envCbie[2*l +: 2] == CBIE_FLUSH);
  end

  assign cboEn[0] = envCbze;
  assign cboEn[1] = envCbcfe;
  assign cboEn[2] = cbieOn;

  // the three cache-block kinds share one gating shape
  for (genvar k = 0; k < NUM_CBO; k++) begin : g_cbo
    assign cboIll[k] = (notM && !cboEn[k][LV_M]) || (isHU && !cboEn[k][LV_S]);
    assign cboVir[k] = cboEn[k][LV_M] &&
                       ((isVS && !cboEn[k][LV_H]) ||
                        (isVU && (!cboEn[k][LV_H] || !cboEn[k][LV_S])));
  end

  always_comb begin
    pathMask = '0;
    if (isHS) pathMask[LV_M] = 1'b1;
    if (isHU) begin
      pathMask[LV_M] = 1'b1;
      pathMask[LV_S] = 1'b1;
    end
    if (isVS) begin
      pathMask[LV_M] = 1'b1;
      pathMask[LV_H] = 1'b1;
    end
    if (isVU) pathMask = '1;
    flushPath = |(pathMask & cbieFlush);
  end

  always_comb begin
    illV = '0;
    virV = '0;
    illV[CL_SFVMA]  = (isHS && tvm) || isHU;
    virV[CL_SFVMA]  = (isVS && vtvm) || isVU;
    illV[CL_SFPART] = isHU;
    virV[CL_SFPART] = isVU;
    illV[CL_HFGV]   = (isHS && tvm) || isHU;
    virV[CL_HFGV]   = isVS || isVU;
    illV[CL_HFVV]   = isHU;
    virV[CL_HFVV]   = isVS || isVU;
    illV[CL_HLSV]   = isHU && !hstatusHu;
    virV[CL_HLSV]   = isVS || isVU;
    illV[CL_FP]     = (fsState == CTX_OFF) || (roundMode > RM_LIMIT);
    illV[CL_VEC]    = (vsState == CTX_OFF);
    illV[CL_WFI]    = isHU || (notM && tw);
    virV[CL_WFI]    = (isVU && !tw) || (isVS && !tw && vtw);
    illV[CL_CBZ]    = cboIll[0];
    virV[CL_CBZ]    = cboVir[0];
    illV[CL_CBCF]   = cboIll[1];
    virV[CL_CBCF]   = cboVir[1];
    illV[CL_CBI]    = cboIll[2];
    virV[CL_CBI]    = cboVir[2];
  end

  always_comb begin
    anyIll    = |(illV & instClass);
    anyVir    = |(virV & instClass);
    nextIll   = anyIll;
    nextVir   = anyVir && !anyIll;
    nextFlush = instClass[CL_CBI] && flushPath && !anyIll && !anyVir;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      illegalQ <= 1'b0;
      virtualQ <= 1'b0;
      flushQ   <= 1'b0;
    end else if (strb.capture) begin
      illegalQ <= nextIll;
      virtualQ <= nextVir;
      flushQ   <= nextFlush;
    end
  end

endmodule

// File: rtl/priv_legal_chk.sv
module priv_legal_chk
  import priv_legal_pkg::*;
#(
  parameter int CLASS_N  = NUM_CLASS,
  parameter int ENV_LVLS = NUM_ENV,
  parameter int RM_W     = 3,
  parameter int RM_MAX   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [MODE_W-1:0]     privMode,
  input  logic [CLASS_N-1:0]    instClass,
  input  logic                  tvm,
  input  logic                  vtvm,
  input  logic                  tw,
  input  logic                  vtw,
  input  logic                  hstatusHu,
  input  logic [1:0]            fsState,
  input  logic [1:0]            vsState,
  input  logic [RM_W-1:0]       roundMode,
  input  logic [ENV_LVLS-1:0]   envCbze,
  input  logic [ENV_LVLS-1:0]   envCbcfe,
  input  logic [2*ENV_LVLS-1:0] envCbie,
  output logic                  outValid,
  output logic                  illegalOut,
  output logic                  virtualOut,
  output logic                  flushOut
);

  dpStrobe_t strb;

  priv_legal_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  priv_legal_dp #(
    .CLASS_N  (CLASS_N),
    .ENV_LVLS (ENV_LVLS),
    .RM_W     (RM_W),
    .RM_MAX   (RM_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .privMode  (privMode),
    .instClass (instClass),
    .tvm       (tvm),
    .vtvm      (vtvm),
    .tw        (tw),
    .vtw       (vtw),
    .hstatusHu (hstatusHu),
    .fsState   (fsState),
    .vsState   (vsState),
    .roundMode (roundMode),
    .envCbze   (envCbze),
    .envCbcfe  (envCbcfe),
    .envCbie   (envCbie),
    .illegalQ  (illegalOut),
    .virtualQ  (virtualOut),
    .flushQ    (flushOut)
  );

endmodule

// File: rtl/priv_legal_chk_sva.sv
module priv_legal_chk_sva
  import priv_legal_pkg::*;
#(
  parameter int CLASS_N = NUM_CLASS
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [MODE_W-1:0]  privMode,
  input logic [CLASS_N-1:0] instClass,
  input logic               outValid,
  input logic               illegalOut,
  input logic               virtualOut,
  input logic               flushOut
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r1_idle_drop: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !illegalOut && !virtualOut && !flushOut);

  a_r11_one_trap: assert property (@(posedge clk) disable iff (!rstN)
    !(illegalOut && virtualOut));

  a_r11_flush_clean: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> outValid && !illegalOut && !virtualOut);

  a_r12_no_virt_host: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (privMode == PM_M || privMode == PM_HS || privMode == PM_HU)
    |=> !virtualOut);

  a_r12_machine_free: assert property (@(posedge clk) disable iff (!rstN)
    inValid && privMode == PM_M && !instClass[CL_FP] && !instClass[CL_VEC]
    |=> !illegalOut && !virtualOut && !flushOut);

  a_r12_no_class: assert property (@(posedge clk) disable iff (!rstN)
    inValid && instClass == '0 |=> !illegalOut && !virtualOut && !flushOut);

endmodule

bind priv_legal_chk priv_legal_chk_sva #(.CLASS_N(CLASS_N)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .privMode   (privMode),
  .instClass  (instClass),
  .outValid   (outValid),
  .illegalOut (illegalOut),
  .virtualOut (virtualOut),
  .flushOut   (flushOut)
);

// File: tb/priv_legal_chk_tb.sv
module priv_legal_chk_tb;

  localparam logic [2:0] M = 3'd0, HS = 3'd1, HU = 3'd2, VS = 3'd3, VU = 3'd4;
  localparam logic [10:0] C_SF = 11'd1 << 0, C_SP = 11'd1 << 1, C_HG = 11'd1 << 2,
    C_HV = 11'd1 << 3, C_HL = 11'd1 << 4, C_FP = 11'd1 << 5, C_VE = 11'd1 << 6,
    C_WF = 11'd1 << 7, C_CZ = 11'd1 << 8, C_CC = 11'd1 << 9, C_CI = 11'd1 << 10;
  localparam logic [1:0] OFF = 2'b00, FL = 2'b01, RSV = 2'b10, INV = 2'b11;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic [2:0] privMode = 3'd0;
  logic [10:0] instClass = '0;
  logic tvm, vtvm, tw, vtw, hstatusHu;
  logic [1:0] fsState, vsState;
  logic [2:0] roundMode;
  logic [2:0] envCbze, envCbcfe;
  logic [5:0] envCbie;
  logic outValid, illegalOut, virtualOut, flushOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  priv_legal_chk u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .privMode(privMode),
    .instClass(instClass), .tvm(tvm), .vtvm(vtvm), .tw(tw), .vtw(vtw),
    .hstatusHu(hstatusHu), .fsState(fsState), .vsState(vsState),
    .roundMode(roundMode), .envCbze(envCbze), .envCbcfe(envCbcfe),
    .envCbie(envCbie), .outValid(outValid), .illegalOut(illegalOut),
    .virtualOut(virtualOut), .flushOut(flushOut)
  );

  task automatic setDefaults();
    tvm = 0; vtvm = 0; tw = 0; vtw = 0; hstatusHu = 1;
    fsState = 2'b11; vsState = 2'b11; roundMode = 3'd0;
    envCbze = 3'b111; envCbcfe = 3'b111; envCbie = {INV, INV, INV};
  endtask

  task automatic expectFlags(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {outValid, illegalOut, virtualOut, flushOut};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,ill,vir,flush} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic runCase(input logic [2:0] m, input logic [10:0] cls,
                         input logic eI, input logic eV, input logic eF, input string tag);
    @(negedge clk);
    privMode = m; instClass = cls; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    expectFlags({1'b1, eI, eV, eF}, tag);
  endtask

  task automatic tReset();
    @(negedge clk);
    expectFlags(4'b0000, "R1 reset state");
  endtask

  task automatic tIdle();
    setDefaults();
    runCase(HU, C_SP, 1, 0, 0, "R1 verdict before idle");
    @(negedge clk);
    expectFlags(4'b0000, "R1 idle clears outputs");
    runCase(VU, 11'd0, 0, 0, 0, "R12 no class selected");
  endtask

  task automatic tSfence();
    setDefaults();
    tvm = 1; runCase(HS, C_SF, 1, 0, 0, "R2 sfence HS tvm=1");
    tvm = 0; runCase(HS, C_SF, 0, 0, 0, "R2 sfence HS tvm=0");
    runCase(HU, C_SF, 1, 0, 0, "R2 sfence HU");
    vtvm = 1; runCase(VS, C_SF, 0, 1, 0, "R2 sfence VS vtvm=1");
    vtvm = 0; runCase(VS, C_SF, 0, 0, 0, "R2 sfence VS vtvm=0");
    runCase(VU, C_SF, 0, 1, 0, "R2 sfence VU");
    tvm = 1; runCase(M, C_SF, 0, 0, 0, "R12 sfence M tvm=1");
    runCase(HS, C_HG, 1, 0, 0, "R2 gvma fence HS tvm=1");
    tvm = 0; runCase(VS, C_HG, 0, 1, 0, "R2 gvma fence VS");
  endtask

  task automatic tPartial();
    setDefaults();
    runCase(HU, C_SP, 1, 0, 0, "R3 partial HU");
    runCase(VU, C_SP, 0, 1, 0, "R3 partial VU");
    runCase(VS, C_SP, 0, 0, 0, "R3 partial VS");
    runCase(HS, C_SP, 0, 0, 0, "R3 partial HS");
  endtask

  task automatic tHfenceVvma();
    setDefaults();
    runCase(HU, C_HV, 1, 0, 0, "R4 vvma HU");
    tvm = 1; runCase(HS, C_HV, 0, 0, 0, "R4 vvma HS tvm=1");
    runCase(VS, C_HV, 0, 1, 0, "R4 vvma VS");
    runCase(VU, C_HV, 0, 1, 0, "R4 vvma VU");
  endtask

  task automatic tHlsv();
    setDefaults();
    hstatusHu = 0; runCase(HU, C_HL, 1, 0, 0, "R5 hlsv HU hu=0");
    hstatusHu = 1; runCase(HU, C_HL, 0, 0, 0, "R5 hlsv HU hu=1");
    runCase(VS, C_HL, 0, 1, 0, "R5 hlsv VS");
    hstatusHu = 0; runCase(HS, C_HL, 0, 0, 0, "R5 hlsv HS");
  endtask

  task automatic tWfi();
    setDefaults();
    runCase(HU, C_WF, 1, 0, 0, "R6 wfi HU tw=0");
    tw = 1; runCase(HS, C_WF, 1, 0, 0, "R6 wfi HS tw=1");
    runCase(M, C_WF, 0, 0, 0, "R6 wfi M tw=1");
    runCase(VU, C_WF, 1, 0, 0, "R6 wfi VU tw=1");
    tw = 0; runCase(HS, C_WF, 0, 0, 0, "R6 wfi HS tw=0");
    runCase(VU, C_WF, 0, 1, 0, "R6 wfi VU tw=0");
    vtw = 1; runCase(VS, C_WF, 0, 1, 0, "R6 wfi VS vtw=1");
    vtw = 0; runCase(VS, C_WF, 0, 0, 0, "R6 wfi VS vtw=0");
  endtask

  task automatic tFpVec();
    setDefaults();
    fsState = OFF; runCase(M, C_FP, 1, 0, 0, "R7 fp off in M");
    fsState = 2'b01; roundMode = 3'd5; runCase(HS, C_FP, 1, 0, 0, "R7 rm=5");
    roundMode = 3'd4; runCase(VU, C_FP, 0, 0, 0, "R7 rm=4");
    vsState = OFF; runCase(HU, C_VE, 1, 0, 0, "R7 vec off");
    vsState = 2'b10; runCase(HU, C_VE, 0, 0, 0, "R7 vec on");
  endtask

  task automatic tCbo();
    setDefaults();
    envCbze = 3'b110; runCase(HS, C_CZ, 1, 0, 0, "R8 zero HS mach=0");
    runCase(M, C_CZ, 0, 0, 0, "R8 zero M mach=0");
    runCase(VS, C_CZ, 1, 0, 0, "R8 zero VS mach=0");
    envCbze = 3'b011; runCase(HU, C_CZ, 1, 0, 0, "R8 zero HU sup=0");
    runCase(HS, C_CZ, 0, 0, 0, "R8 zero HS sup=0");
    runCase(VU, C_CZ, 0, 1, 0, "R8 zero VU sup=0");
    runCase(VS, C_CZ, 0, 0, 0, "R8 zero VS sup=0");
    envCbze = 3'b101; runCase(VS, C_CZ, 0, 1, 0, "R8 zero VS hyp=0");
    envCbcfe = 3'b101; runCase(VU, C_CC, 0, 1, 0, "R8 clean VU hyp=0");
    envCbcfe = 3'b100; runCase(VU, C_CC, 1, 0, 0, "R8 clean VU mach=0");
  endtask

  task automatic tCbi();
    setDefaults();
    envCbie = {INV, INV, OFF}; runCase(HS, C_CI, 1, 0, 0, "R9 inval HS mach off");
    envCbie = {INV, INV, RSV}; runCase(HS, C_CI, 1, 0, 0, "R9 inval mach reserved");
    envCbie = {OFF, INV, INV}; runCase(HU, C_CI, 1, 0, 0, "R9 inval HU sup off");
    runCase(VU, C_CI, 0, 1, 0, "R9 inval VU sup off");
    envCbie = {INV, OFF, INV}; runCase(VS, C_CI, 0, 1, 0, "R9 inval VS hyp off");
    envCbie = {INV, OFF, OFF}; runCase(VS, C_CI, 1, 0, 0, "R9 inval VS mach+hyp off");
    envCbie = {INV, INV, INV}; runCase(VU, C_CI, 0, 0, 0, "R9 inval all enabled");
  endtask

  task automatic tFlush();
    setDefaults();
    envCbie = {INV, INV, FL}; runCase(HS, C_CI, 0, 0, 1, "R10 HS mach flush");
    runCase(M, C_CI, 0, 0, 0, "R10 M never converts");
    envCbie = {FL, INV, INV}; runCase(HU, C_CI, 0, 0, 1, "R10 HU sup flush");
    runCase(HS, C_CI, 0, 0, 0, "R10 HS sup off path");
    runCase(VU, C_CI, 0, 0, 1, "R10 VU sup flush");
    envCbie = {INV, FL, INV}; runCase(VS, C_CI, 0, 0, 1, "R10 VS hyp flush");
    runCase(HU, C_CI, 0, 0, 0, "R10 HU hyp off path");
    envCbie = {OFF, FL, INV}; runCase(VU, C_CI, 0, 1, 0, "R11 VU flush hidden by virtual");
  endtask

  task automatic tPriority();
    setDefaults();
    fsState = OFF; runCase(VU, C_FP | C_HL, 1, 0, 0, "R11 illegal beats virtual");
    fsState = 2'b11; runCase(VU, C_SP | C_HL, 0, 1, 0, "R11 two virtual classes");
    envCbie = {FL, INV, INV}; runCase(VU, C_CI | C_SF, 0, 1, 0, "R11 flush blocked by sfence");
  endtask

  initial begin
    setDefaults();
    repeat (3) @(posedge clk);
    tReset();
    @(negedge clk); rstN = 1'b1;
    tReset();
    tIdle();
    tSfence();
    tPartial();
    tHfenceVvma();
    tHlsv();
    tWfi();
    tFpVec();
    tCbo();
    tCbi();
    tFlush();
    tPriority();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule